// File: doc/BRIEF.md
# Motion Controller Bring-Up Sequencer

This block sits on the host side of an 8-bit parallel port that talks to a motion-control peripheral. After its own reset it takes the peripheral through a fixed start-up routine. It pulses the peripheral's active-low reset and then stays off the port for the peripheral's worst-case internal reset time. Next it reads the status byte and clears all pending interrupt flags with a command followed by a two-byte data word. It reads status a second time and, when the system uses a 12-bit converter, sends the command that widens the converter port.

Port select low addresses the command port, and port select high addresses the data port. Every status read goes to the command port. Between transfers the sequencer polls status until the busy flag clears. If a status check returns a value outside its accepted pair, the sequencer drops the whole attempt and starts again from the reset pulse. It counts each such restart. When the routine completes, the sequencer raises a sticky done flag and leaves the port idle.

Top module: `mcinit_seq`

## Requirements
- R1: The peripheral reset output `dev_rst_n` is low while `rst_n` is low. It stays low for exactly RST_CYC clock cycles after `rst_n` is released, and for exactly RST_CYC cycles on every restart. RST_CYC below 8 is rejected at elaboration.
- R2: While `dev_rst_n` is low, and for at least WAIT_CYC cycles after it rises, `cs_n` stays high.
- R3: A strobe (`rd_n` or `wr_n` low) only occurs with `cs_n` low. The two strobes are never low together. Every read has `ps` = 0.
- R4: The first status read is accepted only when it returns 0xC4 or 0x84. Any other value restarts the sequence at the reset pulse.
- R5: After the first status is accepted, the block writes byte 0x1D with `ps` = 0. It then writes the data word with `ps` = 1: a high byte of 0x00 followed by a low byte of 0x00.
- R6: The busy flag is status bit 0. After the 0x1D command, after the low data byte and after the 0x06 command, the block re-reads status with `ps` = 0 until bit 0 reads 0. It issues no other transfer before then.
- R7: The status read that follows the post-data-word poll is accepted only when it returns 0xC0 or 0x80. Any other value restarts the sequence at the reset pulse.
- R8: With `dac12_en` = 1, the accepted second status is followed by a write of 0x06 with `ps` = 0 and a busy poll. With `dac12_en` = 0, no further write is made.
- R9: `done` rises after the final step and stays high. While `done` is high, the port stays idle.
- R10: `retry_cnt` is 0 after reset and increases by one on each restart, in the same cycle that `dev_rst_n` falls. With RETRY_SAT = 1 it holds at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequencer |
| dac12_en | input | 1 | 1 selects the 12-bit converter step |
| bus_in | input | 8 | Byte read from the peripheral port |
| dev_rst_n | output | 1 | Active-low reset to the peripheral |
| cs_n | output | 1 | Active-low chip select |
| ps | output | 1 | Port select: 0 command/status, 1 data |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| bus_out | output | 8 | Byte driven on writes |
| bus_oe | output | 1 | High while the host drives `bus_out` |
| done | output | 1 | Sequence completed (sticky) |
| retry_cnt | output | RETRY_W | Number of restarts |

## Verification
The model peripheral returns a scripted stream of status bytes. The stream includes a run with no busy responses and a run with repeated busy bytes, so the bench can tell whether the poll loops on bit 0 alone or stops early. Near-miss bytes are also fed to each check: 0xC5, and a second-check value placed at the first check. These show that each check accepts only its own pair and restarts the whole sequence, including the writes that came before it. A long run of rejections shows whether the restart counter saturates. Both settings of the converter option decide whether the trailing command and its poll appear in the write log.

// File: rtl/mcinit_pkg.sv
package mcinit_pkg;

   localparam logic [7:0] OP_IRQ_CLEAR = 8'h1D;
   localparam logic [7:0] OP_WIDE_DAC  = 8'h06;
   localparam logic [7:0] WORD_FILL    = 8'h00;
   localparam logic [7:0] ST1_ACC_A    = 8'hC4;
   localparam logic [7:0] ST1_ACC_B    = 8'h84;
   localparam logic [7:0] ST2_ACC_A    = 8'hC0;
   localparam logic [7:0] ST2_ACC_B    = 8'h80;
   localparam int         BUSY_BIT     = 0;

   typedef enum logic [3:0] {
      S_RSTP, S_WAIT, S_STAT1, S_CMD1, S_POLLA, S_DHI, S_DLO,
      S_POLLB, S_STAT2, S_CMD2, S_POLLC, S_DONE
   } seq_st_t;

   typedef enum logic [1:0] {B_IDLE, B_SET, B_STB, B_HLD} bus_st_t;

   typedef struct packed {
      logic       rd;
      logic       sel;
      logic [7:0] data;
   } xfer_t;

endpackage

// File: rtl/mcinit_tmr.sv
module mcinit_tmr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] CMAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (cnt != CMAX) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/mcinit_rtry.sv
module mcinit_rtry #(
   parameter int W   = 4,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = '1;

   generate
      if (SAT) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt <= '0;
            else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt <= '0;
            else if (inc) cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/mcinit_bus.sv
module mcinit_bus
   import mcinit_pkg::*;
#(
   parameter int STB_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  xfer_t      xf,
   input  logic [7:0] din,
   output logic       idle,
   output logic       ack,
   output logic [7:0] rdata,
   output logic       cs_n,
   output logic       sel,
   output logic       rd_n,
   output logic       wr_n,
   output logic       oe,
   output logic [7:0] dout
);
   localparam int          SW   = $clog2(STB_CYC + 1);
   localparam logic [SW-1:0] SLAST = SW'(STB_CYC - 1);

   bus_st_t       st;
   xfer_t         cur;
   logic [SW-1:0] sc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= B_IDLE;
         cur   <= '0;
         sc    <= '0;
         ack   <= 1'b0;
         rdata <= '0;
      end else begin
         ack <= 1'b0;
         case (st)
            B_IDLE: if (req) begin
               cur <= xf;
               st  <= B_SET;
            end
            B_SET: begin
               sc <= '0;
               st <= B_STB;
            end
            B_STB: begin
               if (sc == SLAST) begin
                  if (cur.rd) rdata <= din;
                  st <= B_HLD;
               end else begin
                  sc <= sc + 1'b1;
               end
            end
            default: begin
               st  <= B_IDLE;
               ack <= 1'b1;
            end
         endcase
      end
   end

   always_comb begin
      idle = (st == B_IDLE);
      cs_n = idle;
      sel  = cur.sel;
      rd_n = !((st == B_STB) && cur.rd);
      wr_n = !((st == B_STB) && !cur.rd);
      oe   = !idle && !cur.rd;
      dout = cur.data;
   end
endmodule

// File: rtl/mcinit_seq.sv
module mcinit_seq
   import mcinit_pkg::*;
#(
   parameter int RST_CYC   = 8,
   parameter int WAIT_CYC  = 75000,
   parameter int STB_CYC   = 2,
   parameter int RETRY_W   = 4,
   parameter bit RETRY_SAT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dac12_en,
   input  logic [7:0]         bus_in,
   output logic               dev_rst_n,
   output logic               cs_n,
   output logic               ps,
   output logic               rd_n,
   output logic               wr_n,
   output logic [7:0]         bus_out,
   output logic               bus_oe,
   output logic               done,
   output logic [RETRY_W-1:0] retry_cnt
);
   localparam int TMR_MAX = (RST_CYC > WAIT_CYC) ? RST_CYC : WAIT_CYC;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam logic [TMR_W-1:0] RST_END  = TMR_W'(RST_CYC - 1);
   localparam logic [TMR_W-1:0] WAIT_END = TMR_W'(WAIT_CYC - 1);

   generate
      if (RST_CYC < 8) begin : g_bad_rst
         $error("RST_CYC must be at least 8");
      end
      if (WAIT_CYC < 1 || STB_CYC < 1 || RETRY_W < 1) begin : g_bad_cfg
         $error("WAIT_CYC, STB_CYC and RETRY_W must be positive");
      end
   endgenerate

   seq_st_t           state, nxt;
   logic [TMR_W-1:0]  tmr;
   logic              tmr_clr;
   logic              restart;
   logic              want, req;
   xfer_t             xf;
   logic              b_idle, b_ack;
   logic [7:0]        b_rdata;
   logic              not_busy, st1_ok, st2_ok;

   mcinit_tmr #(.W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .cnt(tmr)
   );

   mcinit_rtry #(.W(RETRY_W), .SAT(RETRY_SAT)) u_rtry (
      .clk(clk), .rst_n(rst_n), .inc(restart), .cnt(retry_cnt)
   );

   mcinit_bus #(.STB_CYC(STB_CYC)) u_bus (
      .clk(clk), .rst_n(rst_n), .req(req), .xf(xf), .din(bus_in),
      .idle(b_idle), .ack(b_ack), .rdata(b_rdata),
      .cs_n(cs_n), .sel(ps), .rd_n(rd_n), .wr_n(wr_n),
      .oe(bus_oe), .dout(bus_out)
   );

   // Transfer requested by each state.
   always_comb begin
      want = 1'b1;
      xf   = '{rd: 1'b1, sel: 1'b0, data: 8'h00};
      case (state)
         S_STAT1, S_POLLA, S_POLLB, S_STAT2, S_POLLC: ;
         S_CMD1:        xf = '{rd: 1'b0, sel: 1'b0, data: OP_IRQ_CLEAR};
         S_DHI, S_DLO:  xf = '{rd: 1'b0, sel: 1'b1, data: WORD_FILL};
         S_CMD2:        xf = '{rd: 1'b0, sel: 1'b0, data: OP_WIDE_DAC};
         default:       want = 1'b0;
      endcase
      req = want && b_idle && !b_ack;
   end

   assign not_busy = !b_rdata[BUSY_BIT];
   assign st1_ok   = (b_rdata == ST1_ACC_A) || (b_rdata == ST1_ACC_B);
   assign st2_ok   = (b_rdata == ST2_ACC_A) || (b_rdata == ST2_ACC_B);

   always_comb begin
      nxt     = state;
      restart = 1'b0;
      case (state)
         S_RSTP:  if (tmr == RST_END)  nxt = S_WAIT;
         S_WAIT:  if (tmr == WAIT_END) nxt = S_STAT1;
         S_STAT1: if (b_ack) begin
            if (st1_ok) nxt = S_CMD1;
            else begin nxt = S_RSTP; restart = 1'b1; end
         end
         S_CMD1:  if (b_ack) nxt = S_POLLA;
         S_POLLA: if (b_ack && not_busy) nxt = S_DHI;
         S_DHI:   if (b_ack) nxt = S_DLO;
         S_DLO:   if (b_ack) nxt = S_POLLB;
         S_POLLB: if (b_ack && not_busy) nxt = S_STAT2;
         S_STAT2: if (b_ack) begin
            if (!st2_ok) begin nxt = S_RSTP; restart = 1'b1; end
            else if (dac12_en) nxt = S_CMD2;
            else nxt = S_DONE;
         end
         S_CMD2:  if (b_ack) nxt = S_POLLC;
         S_POLLC: if (b_ack && not_busy) nxt = S_DONE;
         default: nxt = S_DONE;
      endcase
      tmr_clr = (nxt != state);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= S_RSTP;
      else        state <= nxt;
   end

   assign dev_rst_n = (state != S_RSTP);
   assign done      = (state == S_DONE);
endmodule

// File: rtl/mcinit_chk.sv
module mcinit_chk #(
   parameter int RST_CYC  = 8,
   parameter int WAIT_CYC = 75000,
   parameter int RETRY_W  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               dev_rst_n,
   input logic               cs_n,
   input logic               ps,
   input logic               rd_n,
   input logic               wr_n,
   input logic               done,
   input logic [RETRY_W-1:0] retry_cnt
);
   localparam int LW = $clog2(RST_CYC + 2) + 1;
   localparam int HW = $clog2(WAIT_CYC + 1) + 1;

   logic [LW-1:0] lowcnt;
   logic [HW-1:0] highcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lowcnt  <= '0;
         highcnt <= '0;
      end else begin
         if (dev_rst_n) lowcnt <= '0;
         else if (lowcnt != '1) lowcnt <= lowcnt + 1'b1;
         if (!dev_rst_n) highcnt <= '0;
         else if (highcnt < HW'(WAIT_CYC)) highcnt <= highcnt + 1'b1;
      end
   end

   assert_rst_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dev_rst_n) |-> (lowcnt == LW'(RST_CYC)));

   assert_quiet_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_rst_n |-> cs_n);

   assert_wait_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (highcnt >= HW'(WAIT_CYC)));

   assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   assert_strobe_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |-> !cs_n);

   assert_read_cmdport_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ps);

   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && rd_n && wr_n));

   assert_retry_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_cnt != $past(retry_cnt)) |-> ($fell(dev_rst_n)
         && (retry_cnt == $past(retry_cnt) + 1'b1)));
endmodule

bind mcinit_seq mcinit_chk #(
   .RST_CYC(RST_CYC), .WAIT_CYC(WAIT_CYC), .RETRY_W(RETRY_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .cs_n(cs_n),
   .ps(ps), .rd_n(rd_n), .wr_n(wr_n), .done(done), .retry_cnt(retry_cnt)
);

// File: tb/mcinit_seq_tb.sv
module mcinit_seq_tb;
   localparam int RST_CYC  = 8;
   localparam int WAIT_CYC = 40;
   localparam int RW       = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dac12_en = 1'b0;
   logic [7:0]    bus_in;
   logic          dev_rst_n, cs_n, ps, rd_n, wr_n, bus_oe, done;
   logic [7:0]    bus_out;
   logic [RW-1:0] retry_cnt;

   always #10 clk = ~clk;

   mcinit_seq #(.RST_CYC(RST_CYC), .WAIT_CYC(WAIT_CYC), .STB_CYC(2),
                .RETRY_W(RW), .RETRY_SAT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .dac12_en(dac12_en), .bus_in(bus_in),
      .dev_rst_n(dev_rst_n), .cs_n(cs_n), .ps(ps), .rd_n(rd_n), .wr_n(wr_n),
      .bus_out(bus_out), .bus_oe(bus_oe), .done(done), .retry_cnt(retry_cnt)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   // Peripheral model: scripted status stream, write log, protocol monitor.
   logic [7:0] stat_seq [0:31];
   logic [8:0] exp_w    [0:15];
   logic [8:0] wlog     [0:15];
   int rd_idx, wcount, pulses, len_bad, gap_bad, gaprun, lowrun;
   int quiet_bad, proto_bad, late_bad;
   bit gap_on, prev_wr, prev_rd;

   assign bus_in = stat_seq[(rd_idx > 31) ? 31 : rd_idx];

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_wr = 1'b1;
         prev_rd = 1'b1;
      end else begin
         if (!dev_rst_n) lowrun++;
         else if (lowrun != 0) begin
            pulses++;
            if (lowrun != RST_CYC) len_bad++;
            lowrun = 0; gaprun = 0; gap_on = 1'b1;
         end
         if (gap_on && dev_rst_n) begin
            if (!cs_n) begin
               if (gaprun < WAIT_CYC) gap_bad++;
               gap_on = 1'b0;
            end else gaprun++;
         end
         if (!dev_rst_n && !cs_n) quiet_bad++;
         if (!rd_n && !wr_n) proto_bad++;
         if ((!rd_n || !wr_n) && cs_n) proto_bad++;
         if (!rd_n && ps) proto_bad++;
         if (done && !cs_n) late_bad++;
         if (!wr_n && prev_wr) begin
            if (wcount < 16) wlog[wcount] = {ps, bus_out};
            wcount++;
         end
         if (rd_n && !prev_rd) rd_idx++;
         prev_wr = wr_n;
         prev_rd = rd_n;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, expv, expv);
      end
   endtask

   task automatic set_st(input int i, input logic [7:0] v);
      stat_seq[i] = v;
   endtask

   task automatic clear_model();
      for (int i = 0; i < 32; i++) stat_seq[i] = 8'h00;
      for (int i = 0; i < 16; i++) begin exp_w[i] = '0; wlog[i] = '0; end
      rd_idx = 0; wcount = 0; pulses = 0; len_bad = 0; gap_bad = 0;
      gaprun = 0; lowrun = 0; quiet_bad = 0; proto_bad = 0; late_bad = 0;
      gap_on = 1'b0;
   endtask

   // Common run: reset, release, wait for done, compare against expectations.
   task automatic run_case(input string nm, input bit dac, input int nrd,
                           input int nwr, input int exp_retry, input int exp_pulses);
      int cyc;
      @(negedge clk);
      rst_n = 1'b0;
      dac12_en = dac;
      repeat (3) @(negedge clk);
      check(dev_rst_n == 1'b0, {"R1 reset low during rst_n ", nm}, dev_rst_n, 0);
      check({cs_n, rd_n, wr_n} == 3'b111, {"R2 port idle in reset ", nm}, {cs_n, rd_n, wr_n}, 7);
      check(done == 1'b0 && retry_cnt == '0, {"R10 reset state ", nm}, {done, retry_cnt}, 0);
      @(posedge clk);
      #5 rst_n = 1'b1;
      cyc = 0;
      while (!done && cyc < 5000) begin
         @(negedge clk);
         cyc++;
      end
      check(done == 1'b1, {"R9 done reached ", nm}, done, 1);
      repeat (20) @(negedge clk);
      check(done == 1'b1 && late_bad == 0, {"R9 done sticky and idle ", nm}, late_bad, 0);
      check(pulses == exp_pulses && len_bad == 0, {"R1 reset pulses ", nm}, pulses * 100 + len_bad, exp_pulses * 100);
      check(gap_bad == 0 && quiet_bad == 0, {"R2 wait window ", nm}, gap_bad + quiet_bad, 0);
      check(proto_bad == 0, {"R3 strobe protocol ", nm}, proto_bad, 0);
      check(rd_idx == nrd, {"R6 status read count ", nm}, rd_idx, nrd);
      check(wcount == nwr, {"R5 write count ", nm}, wcount, nwr);
      for (int i = 0; i < nwr && i < 16; i++)
         check(wlog[i] == exp_w[i], {"R5 write byte ", nm}, wlog[i], exp_w[i]);
      check(retry_cnt == RW'(exp_retry), {"R10 retry count ", nm}, retry_cnt, exp_retry);
   endtask

   task automatic t_clean_dac12();   // R4 R5 R6 R7 R8
      clear_model();
      set_st(0, 8'hC4); set_st(1, 8'h00); set_st(2, 8'h00); set_st(3, 8'hC0); set_st(4, 8'h00);
      exp_w[0] = 9'h01D; exp_w[1] = 9'h100; exp_w[2] = 9'h100; exp_w[3] = 9'h006;
      run_case("clean_dac12 R8", 1'b1, 5, 4, 0, 1);
   endtask

   task automatic t_busy_8bit();     // R6 busy polling, R8 skip
      clear_model();
      set_st(0, 8'h84); set_st(1, 8'h01); set_st(2, 8'h01); set_st(3, 8'h00);
      set_st(4, 8'h41); set_st(5, 8'h00); set_st(6, 8'h80);
      exp_w[0] = 9'h01D; exp_w[1] = 9'h100; exp_w[2] = 9'h100;
      run_case("busy_8bit R6 R8", 1'b0, 7, 3, 0, 1);
   endtask

   task automatic t_bad_first();     // R4 near miss 0xC5
      clear_model();
      set_st(0, 8'hC5); set_st(1, 8'hC4); set_st(2, 8'h00); set_st(3, 8'h00);
      set_st(4, 8'hC0); set_st(5, 8'h03); set_st(6, 8'h02);
      exp_w[0] = 9'h01D; exp_w[1] = 9'h100; exp_w[2] = 9'h100; exp_w[3] = 9'h006;
      run_case("bad_first R4", 1'b1, 7, 4, 1, 2);
   endtask

   task automatic t_bad_second();    // R7 restart after a full word
      clear_model();
      set_st(0, 8'hC4); set_st(1, 8'h00); set_st(2, 8'h00); set_st(3, 8'hC8);
      set_st(4, 8'h84); set_st(5, 8'h00); set_st(6, 8'h00); set_st(7, 8'h80);
      exp_w[0] = 9'h01D; exp_w[1] = 9'h100; exp_w[2] = 9'h100;
      exp_w[3] = 9'h01D; exp_w[4] = 9'h100; exp_w[5] = 9'h100;
      run_case("bad_second R7", 1'b0, 8, 6, 1, 2);
   endtask

   task automatic t_saturate();      // R10 saturation, R4 rejects 0xC0
      clear_model();
      set_st(0, 8'h00); set_st(1, 8'h44); set_st(2, 8'hC0); set_st(3, 8'h80); set_st(4, 8'h04);
      set_st(5, 8'hC4); set_st(6, 8'h00); set_st(7, 8'h00); set_st(8, 8'h80);
      exp_w[0] = 9'h01D; exp_w[1] = 9'h100; exp_w[2] = 9'h100;
      run_case("saturate R10", 1'b0, 9, 3, 3, 6);
   endtask

   initial begin
      clear_model();
      t_clean_dac12();
      t_busy_8bit();
      t_bad_first();
      t_bad_second();
      t_saturate();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule